// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block joins two 18-bit ports, A and B, with one storage path in each direction. Each path has four controls of its own: an active-low drive enable, a latch enable, a data strobe and an active-low strobe enable. A path runs in one of three ways. It can pass data straight through. It can hold a stored word. It can capture a new word on a rising strobe edge. The path toward B is driven from the A inputs, and the path toward A mirrors it from the B inputs. The two paths share no state.

The external strobes are asynchronous to the block. Each one is sampled by the free-running system clock. A rising edge is recognised when one sample is low and the next is high. While a path's latch enable is high, the output is a combinational bypass of the input, and the storage reloads on every system clock. When the latch enable falls, the storage keeps the last word it passed. The block does not drive tri-state pads itself. Each port has a data output and a drive flag, and the pad ring turns these into a high-impedance output.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: After reset, both storage words are zero. A strobe that is already high when reset is released is not treated as a rising edge.
- R2: When a path's drive enable is high, the drive flag on that path's output port is low, whatever the latch, strobe and data inputs are. When the drive enable is low, the drive flag is high in the same cycle.
- R3: When the latch enable is high, the output port shows the opposite port's input word in the same cycle, without waiting for a system clock edge.
- R4: When the latch enable is high, the storage loads the input word at every system clock edge. After the latch enable falls, the output keeps showing the last word loaded.
- R5: When the latch enable and the strobe enable are both low, a strobe edge captures the input word. A strobe edge means one system-clock sample low followed by the next sample high. The captured word appears on the output in the cycle after the edge is seen.
- R6: When the latch enable is low and the strobe stays steady (high or low), or the strobe falls, the output keeps its stored word.
- R7: When the strobe enable is high, strobe edges are ignored and the stored word is kept.
- R8: The stored word is kept while the drive flag is low. When the drive enable goes low again, the output shows that stored word.
- R9: The B-to-A path behaves like the A-to-B path, using its own controls. Activity on one path never changes the other path's output or drive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Word received on port A |
| a_out | output | 18 | Word presented to port A |
| a_drive | output | 1 | Drive flag for port A; high means a_out is driven |
| b_in | input | 18 | Word received on port B |
| b_out | output | 18 | Word presented to port B |
| b_drive | output | 1 | Drive flag for port B; high means b_out is driven |
| ab_oe_n | input | 1 | Active-low drive enable, A-to-B path |
| ab_le | input | 1 | Latch enable, A-to-B path |
| ab_strobe | input | 1 | Capture strobe, A-to-B path |
| ab_stb_en_n | input | 1 | Active-low strobe enable, A-to-B path |
| ba_oe_n | input | 1 | Active-low drive enable, B-to-A path |
| ba_le | input | 1 | Latch enable, B-to-A path |
| ba_strobe | input | 1 | Capture strobe, B-to-A path |
| ba_stb_en_n | input | 1 | Active-low strobe enable, B-to-A path |

## Verification
The hardest case to reach is a strobe edge whose low and high samples straddle a change in the enables. The stimulus holds the strobe low for one full system clock, then raises it. The strobe enable is either set or cleared during that window, so the bench can show both a capture and an ignored edge. A second hard case is keeping a word while the outputs are disabled. The bench drives new input words while the drive enable is high, then re-enables the output and checks that the stored word is unchanged. The drive enables of both paths are also set active together. The bench reports that contention and does not check the output values while it lasts.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int XCVR_WIDTH = 18;

    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,
        MODE_HOLD    = 2'd1,
        MODE_CAPTURE = 2'd2
    } lane_mode_e;
endpackage

// File: rtl/xcvr_edge_detect.sv
module xcvr_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1};
        else        st_q <= st_d;
    end

    assign rise_o = sig_i && !st_q.prev;

    // R5
    no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int WIDTH = XCVR_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_i,
    input  logic             oe_n_i,
    input  logic             le_i,
    input  logic             strobe_i,
    input  logic             stb_en_n_i,
    output logic [WIDTH-1:0] data_o,
    output logic             drive_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } lane_state_t;

    lane_state_t st_d, st_q;
    lane_mode_e  mode;
    logic        rise;

    xcvr_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (strobe_i),
        .rise_o (rise)
    );

    always_comb begin
        st_d = st_q;
        if (le_i)                     mode = MODE_PASS;
        else if (rise && !stb_en_n_i) mode = MODE_CAPTURE;
        else                          mode = MODE_HOLD;
        if (mode != MODE_HOLD) st_d.word = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = (mode == MODE_PASS) ? data_i : st_q.word;
    assign drive_o = !oe_n_i;

    // R4
    pass_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_i |=> (st_q.word == $past(data_i)));

    // R5
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && !stb_en_n_i && rise) |=> (st_q.word == $past(data_i)));

    // R6
    steady_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && !rise) |=> $stable(st_q.word));

    // R7
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && stb_en_n_i) |=> $stable(st_q.word));
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH = XCVR_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive,
    input  logic             ab_oe_n,
    input  logic             ab_le,
    input  logic             ab_strobe,
    input  logic             ab_stb_en_n,
    input  logic             ba_oe_n,
    input  logic             ba_le,
    input  logic             ba_strobe,
    input  logic             ba_stb_en_n
);
    xcvr_lane #(.WIDTH(WIDTH)) u_ab (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_i     (a_in),
        .oe_n_i     (ab_oe_n),
        .le_i       (ab_le),
        .strobe_i   (ab_strobe),
        .stb_en_n_i (ab_stb_en_n),
        .data_o     (b_out),
        .drive_o    (b_drive)
    );

    xcvr_lane #(.WIDTH(WIDTH)) u_ba (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_i     (b_in),
        .oe_n_i     (ba_oe_n),
        .le_i       (ba_le),
        .strobe_i   (ba_strobe),
        .stb_en_n_i (ba_stb_en_n),
        .data_o     (a_out),
        .drive_o    (a_drive)
    );

    // R9
    ab_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(a_in) && $stable(ab_le) && !ab_le && !ab_strobe) |=> $stable(b_out));
endmodule

// File: tb/bidir_latch_xcvr_tb.sv
module bidir_latch_xcvr_tb;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive;
    logic ab_oe_n = 1'b0, ab_le = 1'b0, ab_strobe = 1'b1, ab_stb_en_n = 1'b0;
    logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_strobe = 1'b1, ba_stb_en_n = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int n_contention = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bidir_latch_xcvr u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_strobe(ab_strobe), .ab_stb_en_n(ab_stb_en_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_strobe(ba_strobe), .ba_stb_en_n(ba_stb_en_n)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        a_in = 18'h2ABCD;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(2);
        chk("R1 b_out after reset", b_out, '0);
        chk("R1 a_out after reset", a_out, '0);
        chk("R2 b_drive enabled", {17'd0, b_drive}, 18'd1);
        chk("R2 a_drive disabled", {17'd0, a_drive}, 18'd0);
    endtask

    task automatic t_transparent();
        ab_le = 1'b1; a_in = 18'h11111;
        #1 chk("R3 pass same cycle", b_out, 18'h11111);
        a_in = 18'h3C3C3; #1 chk("R3 pass follows", b_out, 18'h3C3C3);
        step();
        ab_le = 1'b0; a_in = 18'h0F0F0;
        step();
        chk("R4 retains last passed", b_out, 18'h3C3C3);
    endtask

    task automatic t_capture();
        ab_strobe = 1'b0; a_in = 18'h2468A;
        step();
        chk("R6 steady low hold", b_out, 18'h3C3C3);
        ab_strobe = 1'b1;
        #1 chk("R5 not before edge sampled", b_out, 18'h3C3C3);
        step();
        chk("R5 captured", b_out, 18'h2468A);
        a_in = 18'h13579;
        step(2);
        chk("R6 steady high hold", b_out, 18'h2468A);
        ab_strobe = 1'b0;
        step();
        chk("R6 falling no capture", b_out, 18'h2468A);
    endtask

    task automatic t_gate();
        ab_stb_en_n = 1'b1; a_in = 18'h1FFFF;
        ab_strobe = 1'b1; step();
        ab_strobe = 1'b0; step();
        ab_strobe = 1'b1; step();
        chk("R7 gated edge ignored", b_out, 18'h2468A);
        ab_strobe = 1'b0; ab_stb_en_n = 1'b0; step();
        ab_strobe = 1'b1; step();
        chk("R7 ungated edge captures", b_out, 18'h1FFFF);
    endtask

    task automatic t_tristate();
        ab_oe_n = 1'b1; ab_le = 1'b1; a_in = 18'h0AAAA;
        #1 chk("R2 drive off in pass", {17'd0, b_drive}, 18'd0);
        step();
        ab_le = 1'b0; a_in = 18'h35555;
        ab_strobe = 1'b0; step();
        chk("R2 drive off in hold", {17'd0, b_drive}, 18'd0);
        ab_strobe = 1'b1; ab_stb_en_n = 1'b1; step(3);
        ab_oe_n = 1'b0;
        #1 chk("R2 drive back on", {17'd0, b_drive}, 18'd1);
        chk("R8 word kept while disabled", b_out, 18'h0AAAA);
        ab_stb_en_n = 1'b0;
    endtask

    task automatic t_mirror();
        logic [W-1:0] b_snap;
        b_snap = b_out;
        ab_oe_n = 1'b1; ba_oe_n = 1'b0;
        ba_le = 1'b1; b_in = 18'h00777;
        #1 chk("R9 ba pass", a_out, 18'h00777);
        step();
        ba_le = 1'b0; ba_strobe = 1'b0; b_in = 18'h3E000; step();
        chk("R9 ba retains", a_out, 18'h00777);
        ba_strobe = 1'b1; step();
        chk("R9 ba capture", a_out, 18'h3E000);
        ba_stb_en_n = 1'b1; ba_strobe = 1'b0; b_in = 18'h12345; step();
        ba_strobe = 1'b1; step();
        chk("R9 ba gated", a_out, 18'h3E000);
        chk("R9 ab unaffected", b_out, b_snap);
        chk("R9 ab drive unaffected", {17'd0, b_drive}, 18'd0);
    endtask

    task automatic t_contention();
        ab_oe_n = 1'b0; ba_oe_n = 1'b0;
        #1;
        if (a_drive && b_drive) begin
            n_contention++;
            $display("NOTE: bus contention, both ports driven");
        end
        chk("R2 both enables honoured", {16'd0, a_drive, b_drive}, 18'd3);
        ba_oe_n = 1'b1;
        step();
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_capture();
        t_gate();
        t_tristate();
        t_mirror();
        t_contention();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule